// File: doc/BRIEF.md
# Shunt Overpower Protection Controller

This block decides when a serially powered chip should collapse its own supply voltage. A flash converter measures the shunt current and delivers a thermometer word from its comparator bank. The controller turns that word into a 6-bit code. It compares the code with a programmable threshold, and it raises a current alarm only after the overcurrent has lasted for a programmable number of clocks. The current alarm is off after reset and must be armed before it can trip anything.

The block enters a latched protection state when the current alarm trips or when a power-down command arrives. In that state it decouples the shunt regulation amplifier and ties the shunt gate to the buffer supply. The shunt keeps carrying the string current while the local voltage drops to a few tens of millivolts, so power falls while the current stays the same.

A release command ends protection. The amplifier then stays decoupled for a fixed recharge ramp before normal regulation resumes. The range setting for the converter's LSB is passed straight through to the analog side. The latest code, a sticky alarm flag and the protection state are outputs, so the command bus can read them back.

Top module: `ovp_ctrl`

## Requirements
- R1: After reset, code_o, alarm_o, prot_o, amp_decouple_o and gate_to_buf_o are all 0, and the alarm enable is cleared.
- R2: Each cycle, code_o is updated with the number of consecutive ones counted upward from comparator bit 0 of the bubble-corrected thermometer word. It is registered once, so it appears one clock after therm_i is sampled. All 63 ones give 63.
- R3: Bubble correction replaces each comparator bit with the majority of itself and its two neighbours. A 1 is assumed below bit 0 and a 0 above bit 62. A single zero inside the run of ones and an isolated one above the run therefore do not change the code, while a zero at bit 0 with ones above it reads as 63.
- R4: lsb_tune_o equals lsb_tune_i at all times.
- R5: The alarm enable is written from alarm_en_d_i in a cycle where alarm_en_we_i is 1. While it is 0, no code value can set alarm_o or enter protection.
- R6: With the enable set, a trip occurs at the clock edge that ends the 2^delay_sel_i-th consecutive cycle in which code_o >= thresh_i. Any cycle where this condition is false restarts the count, and the trip repeats every cycle for as long as the condition holds.
- R7: alarm_o is set by a trip and stays set until a release is accepted while in protection. A trip in the same cycle as the release wins.
- R8: A trip or pd_cmd_i while not in protection sets prot_o, amp_decouple_o and gate_to_buf_o at the next edge. gate_to_buf_o is never 1 without amp_decouple_o.
- R9: Protection holds until rel_cmd_i is seen in protection. rel_cmd_i outside protection has no effect.
- R10: After a release, amp_decouple_o stays 1 with prot_o and gate_to_buf_o at 0 for 16 cycles, and then all three go to 0. A trip or pd_cmd_i during those cycles returns the block to protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | 63 | Flash comparator outputs, bit 0 lowest threshold |
| lsb_tune_i | input | 4 | Converter LSB range setting |
| thresh_i | input | 6 | Overcurrent code threshold |
| delay_sel_i | input | 4 | Persistence exponent, count is 2^value cycles |
| alarm_en_we_i | input | 1 | Write strobe for the alarm enable |
| alarm_en_d_i | input | 1 | Alarm enable write data |
| pd_cmd_i | input | 1 | Power-down command |
| rel_cmd_i | input | 1 | Release command |
| lsb_tune_o | output | 4 | LSB range setting to the converter |
| code_o | output | 6 | Latest current code |
| alarm_o | output | 1 | Sticky current alarm |
| prot_o | output | 1 | Protection state active |
| amp_decouple_o | output | 1 | Shunt amplifier disconnected |
| gate_to_buf_o | output | 1 | Shunt gate tied to buffer supply |

## Verification
If the encoder is wrong, code_o shows it one clock after the thermometer word is sampled. A persistence counter that is off by even one cycle moves the rise of prot_o and alarm_o by that cycle. A bad protection or ramp state shows at once on amp_decouple_o or gate_to_buf_o, or when the ramp ends a cycle early or late. The bench runs a reference model in step with the design and compares every output on every clock. Any of these faults is therefore caught in the first cycle where it shows at a port.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  localparam int ADC_W    = 6;
  localparam int NTAP     = (1 << ADC_W) - 1;
  localparam int DLY_W    = 4;
  localparam int CNT_W    = (1 << DLY_W);
  localparam int TUNE_W   = 4;
  localparam int RAMP_LEN = 16;
  localparam int RAMP_W   = $clog2(RAMP_LEN);

  typedef enum logic [1:0] {
    PS_RUN  = 2'd0,
    PS_HOLD = 2'd1,
    PS_RAMP = 2'd2
  } prot_state_e;
endpackage

// File: rtl/ovp_therm_enc.sv
module ovp_therm_enc #(
  parameter int ADC_W = ovp_pkg::ADC_W,
  localparam int NT   = (1 << ADC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NT-1:0]    therm_i,
  output logic [ADC_W-1:0] code_o
);
  logic [NT+1:0]    ext;
  logic [NT-1:0]    fix;
  logic [ADC_W-1:0] code_d;
  logic [ADC_W-1:0] code_q;

  // pad: assumed one below the lowest tap, zero above the highest
  assign ext = {1'b0, therm_i, 1'b1};

  for (genvar i = 0; i < NT; i++) begin : g_maj
    assign fix[i] = (ext[i] & ext[i+1]) | (ext[i+1] & ext[i+2]) | (ext[i] & ext[i+2]);
  end

  always_comb begin
    logic hit;
    hit    = 1'b0;
    code_d = ADC_W'(NT);
    for (int i = 0; i < NT; i++) begin
      if (!hit && !fix[i]) begin
        code_d = ADC_W'(i);
        hit    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/ovp_persist.sv
module ovp_persist #(
  parameter int ADC_W = ovp_pkg::ADC_W,
  parameter int DLY_W = ovp_pkg::DLY_W,
  localparam int CNT_W = (1 << DLY_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ADC_W-1:0] code_i,
  input  logic [ADC_W-1:0] thresh_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             en_i,
  output logic             trip_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             over;

  assign lim    = (CNT_W'(1) << dly_i) - CNT_W'(1);
  assign over   = en_i && (code_i >= thresh_i);
  assign trip_o = over && (cnt_q == lim);

  // saturates at the limit so the trip stays asserted while overcurrent persists
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!over)           cnt_q <= '0;
    else if (cnt_q != lim)    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/ovp_prot_fsm.sv
module ovp_prot_fsm #(
  parameter int RAMP_LEN = ovp_pkg::RAMP_LEN,
  localparam int RAMP_W  = $clog2(RAMP_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic pd_i,
  input  logic rel_i,
  output logic alarm_o,
  output logic prot_o,
  output logic decouple_o,
  output logic gate_o
);
  import ovp_pkg::*;

  prot_state_e       state_q, state_d;
  logic [RAMP_W-1:0] rc_q, rc_d;
  logic              alarm_q;
  logic              rel_ok;

  assign rel_ok = (state_q == PS_HOLD) && rel_i;

  always_comb begin
    state_d = state_q;
    rc_d    = rc_q;
    unique case (state_q)
      PS_RUN:  if (trip_i || pd_i) state_d = PS_HOLD;
      PS_HOLD: if (rel_i) begin
                 state_d = PS_RAMP;
                 rc_d    = '0;
               end
      PS_RAMP: begin
        if (trip_i || pd_i)                         state_d = PS_HOLD;
        else if (rc_q == RAMP_W'(RAMP_LEN - 1))     state_d = PS_RUN;
        else                                        rc_d    = rc_q + RAMP_W'(1);
      end
      default: state_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
      rc_q    <= '0;
      alarm_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rc_q    <= rc_d;
      if (trip_i)      alarm_q <= 1'b1;
      else if (rel_ok) alarm_q <= 1'b0;
    end
  end

  assign alarm_o    = alarm_q;
  assign prot_o     = (state_q == PS_HOLD);
  assign gate_o     = (state_q == PS_HOLD);
  assign decouple_o = (state_q != PS_RUN);
endmodule

// File: rtl/ovp_ctrl.sv
module ovp_ctrl #(
  parameter int ADC_W    = ovp_pkg::ADC_W,
  parameter int DLY_W    = ovp_pkg::DLY_W,
  parameter int TUNE_W   = ovp_pkg::TUNE_W,
  parameter int RAMP_LEN = ovp_pkg::RAMP_LEN,
  localparam int NT      = (1 << ADC_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NT-1:0]     therm_i,
  input  logic [TUNE_W-1:0] lsb_tune_i,
  input  logic [ADC_W-1:0]  thresh_i,
  input  logic [DLY_W-1:0]  delay_sel_i,
  input  logic              alarm_en_we_i,
  input  logic              alarm_en_d_i,
  input  logic              pd_cmd_i,
  input  logic              rel_cmd_i,
  output logic [TUNE_W-1:0] lsb_tune_o,
  output logic [ADC_W-1:0]  code_o,
  output logic              alarm_o,
  output logic              prot_o,
  output logic              amp_decouple_o,
  output logic              gate_to_buf_o
);
  logic             alarm_en_q;
  logic             trip;
  logic [ADC_W-1:0] code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            alarm_en_q <= 1'b0;
    else if (alarm_en_we_i) alarm_en_q <= alarm_en_d_i;
  end

  ovp_therm_enc #(.ADC_W(ADC_W)) u_enc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .therm_i (therm_i),
    .code_o  (code)
  );

  ovp_persist #(.ADC_W(ADC_W), .DLY_W(DLY_W)) u_per (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (code),
    .thresh_i (thresh_i),
    .dly_i    (delay_sel_i),
    .en_i     (alarm_en_q),
    .trip_o   (trip)
  );

  ovp_prot_fsm #(.RAMP_LEN(RAMP_LEN)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trip_i     (trip),
    .pd_i       (pd_cmd_i),
    .rel_i      (rel_cmd_i),
    .alarm_o    (alarm_o),
    .prot_o     (prot_o),
    .decouple_o (amp_decouple_o),
    .gate_o     (gate_to_buf_o)
  );

  assign code_o     = code;
  assign lsb_tune_o = lsb_tune_i;
endmodule

// File: rtl/ovp_ctrl_chk.sv
module ovp_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_cmd_i,
  input logic rel_cmd_i,
  input logic alarm_en_q,
  input logic alarm_o,
  input logic prot_o,
  input logic amp_decouple_o,
  input logic gate_to_buf_o
);
  a_r8_pd_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_cmd_i && !prot_o) |=> prot_o);

  a_r8_gate_needs_decouple: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_to_buf_o |-> amp_decouple_o);

  a_r9_hold_until_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_o && !rel_cmd_i) |=> prot_o);

  a_r10_release_ramp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_o && rel_cmd_i) |=> (amp_decouple_o && !prot_o && !gate_to_buf_o));

  a_r7_alarm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_o && !(prot_o && rel_cmd_i)) |=> alarm_o);

  a_r5_no_trip_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alarm_en_q && !alarm_o) |=> !alarm_o);
endmodule

bind ovp_ctrl ovp_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pd_cmd_i       (pd_cmd_i),
  .rel_cmd_i      (rel_cmd_i),
  .alarm_en_q     (alarm_en_q),
  .alarm_o        (alarm_o),
  .prot_o         (prot_o),
  .amp_decouple_o (amp_decouple_o),
  .gate_to_buf_o  (gate_to_buf_o)
);

// File: tb/sim_ovp_ctrl.sv
`timescale 1ns/1ps
module sim_ovp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [62:0] therm = '0;
  logic [3:0]  lsb = '0;
  logic [5:0]  thresh = '0;
  logic [3:0]  dly = '0;
  logic        en_we = 1'b0, en_d = 1'b0, pd = 1'b0, rel = 1'b0;
  logic [3:0]  lsb_o;
  logic [5:0]  code_o;
  logic        alarm_o, prot_o, dec_o, gate_o;

  int checks = 0, errors = 0;
  bit run = 0;

  always #4 clk = ~clk;

  ovp_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .therm_i(therm), .lsb_tune_i(lsb),
    .thresh_i(thresh), .delay_sel_i(dly), .alarm_en_we_i(en_we),
    .alarm_en_d_i(en_d), .pd_cmd_i(pd), .rel_cmd_i(rel),
    .lsb_tune_o(lsb_o), .code_o(code_o), .alarm_o(alarm_o),
    .prot_o(prot_o), .amp_decouple_o(dec_o), .gate_to_buf_o(gate_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int m_code = 0, m_cnt = 0, m_st = 0, m_rc = 0;
  bit m_en = 0, m_alarm = 0;

  function automatic int enc(logic [62:0] t);
    bit b [0:64];
    b[0] = 1; b[64] = 0;
    for (int i = 0; i < 63; i++) b[i+1] = t[i];
    for (int i = 0; i < 63; i++) begin
      int s = int'(b[i]) + int'(b[i+1]) + int'(b[i+2]);
      if (s < 2) return i;
    end
    return 63;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_cnt = 0; m_st = 0; m_rc = 0; m_en = 0; m_alarm = 0;
    end else begin
      bit over, trip, relok;
      int lim;
      lim   = (1 << dly) - 1;
      over  = m_en && (m_code >= thresh);
      trip  = over && (m_cnt == lim);
      relok = (m_st == 1) && rel;
      if (!over) m_cnt = 0; else if (m_cnt != lim) m_cnt++;
      case (m_st)
        0: if (trip || pd) m_st = 1;
        1: if (rel) begin m_st = 2; m_rc = 0; end
        default: if (trip || pd) m_st = 1;
                 else if (m_rc == 15) m_st = 0;
                 else m_rc++;
      endcase
      if (trip) m_alarm = 1; else if (relok) m_alarm = 0;
      m_code = enc(therm);
      if (en_we) m_en = en_d;
    end
  end

  always @(negedge clk) if (run && rst_n) begin
    chk("R2 code", code_o, m_code);
    chk("R4 lsb", lsb_o, lsb);
    chk("R7 alarm", alarm_o, m_alarm);
    chk("R9 prot", prot_o, m_st == 1);
    chk("R10 decouple", dec_o, m_st != 0);
    chk("R8 gate", gate_o, m_st == 1);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  function automatic logic [62:0] ones(int k);
    logic [62:0] v = '0;
    for (int i = 0; i < k; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    run = 1;
    tick();
    // R1 reset state
    chk("R1 code", code_o, 0);
    chk("R1 alarm", alarm_o, 0);
    chk("R1 prot", prot_o, 0);
    chk("R1 decouple", dec_o, 0);
    chk("R1 gate", gate_o, 0);

    // R2 plain codes
    foreach (int_arr[i]) ;
    therm = ones(5);  tick(); chk("R2 five", code_o, 5);
    therm = ones(63); tick(); chk("R2 full", code_o, 63);
    therm = ones(32); tick(); chk("R2 half", code_o, 32);
    lsb = 4'hA;       tick(); chk("R4 lsb", lsb_o, 10);

    // R3 bubbles
    therm = ones(20); therm[10] = 1'b0; tick(); chk("R3 single bubble", code_o, 20);
    therm = ones(20); therm[10] = 1'b0; therm[11] = 1'b0; tick(); chk("R3 double bubble", code_o, 10);
    therm = ones(20); therm[30] = 1'b1; tick(); chk("R3 stray one", code_o, 20);
    therm = ones(63); therm[0] = 1'b0; tick(); chk("R3 bottom bubble", code_o, 63);

    // R5 disabled alarm: no trip
    thresh = 6'd0; dly = 4'd0; therm = ones(40);
    tick(20);
    chk("R5 no prot", prot_o, 0);
    chk("R5 no alarm", alarm_o, 0);

    // R6 persistence 2^2 cycles
    thresh = 6'd30; dly = 4'd2;
    en_we = 1; en_d = 1; tick(); en_we = 0;
    tick(3); chk("R6 before trip", prot_o, 0);
    tick();  chk("R6 trip", prot_o, 1);
    chk("R7 alarm set", alarm_o, 1);

    // R7/R10 release and ramp
    therm = '0; tick();
    rel = 1; tick(); rel = 0;
    chk("R7 alarm cleared", alarm_o, 0);
    chk("R10 ramp decouple", dec_o, 1);
    chk("R10 ramp gate", gate_o, 0);
    tick(15); chk("R10 ramp end-1", dec_o, 1);
    tick();   chk("R10 ramp done", dec_o, 0);

    // R9 release ignored when idle
    rel = 1; tick(); rel = 0;
    chk("R9 idle release", dec_o, 0);

    // R8 power-down command
    pd = 1; tick(); pd = 0;
    chk("R8 pd prot", prot_o, 1);
    chk("R8 pd gate", gate_o, 1);
    chk("R8 pd no alarm", alarm_o, 0);
    tick(10); chk("R9 held", prot_o, 1);
    rel = 1; tick(); rel = 0;
    tick(5);
    pd = 1; tick(); pd = 0;
    chk("R10 pd in ramp", prot_o, 1);
    rel = 1; tick(); rel = 0;
    tick(20);

    // R6 interrupted persistence, 2^3 cycles
    dly = 4'd3;
    therm = ones(40); tick(5);
    therm = '0;       tick();
    therm = ones(40); tick(8);
    chk("R6 restart no trip", prot_o, 0);
    tick();
    chk("R6 restart trip", prot_o, 1);
    therm = '0; tick(2);
    rel = 1; tick(); rel = 0;
    tick(20);

    // mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int lvl = $urandom_range(0, 63);
      therm = ones(lvl);
      if ($urandom_range(0, 7) == 0) therm[$urandom_range(0, 62)] ^= 1'b1;
      lsb   = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 99) == 0) thresh = 6'($urandom_range(20, 63));
      if ($urandom_range(0, 199) == 0) dly = 4'($urandom_range(0, 3));
      pd    = ($urandom_range(0, 79) == 0);
      rel   = ($urandom_range(0, 14) == 0);
      en_we = ($urandom_range(0, 149) == 0);
      en_d  = $urandom_range(0, 3) != 0;
      tick();
    end
    pd = 0; rel = 0; en_we = 0;
    tick(2);
    finish_run();
  end

  int int_arr [0:0];
endmodule